// File: doc/BRIEF.md
# Fully Associative Cache with First-In First-Out Replacement

This block sits between a processor and a slower main memory and keeps a small set of address/data pairs close to the processor. Each slot keeps the complete word address beside its data, so any memory word may live in any slot. Every lookup compares the incoming address against all occupied slots at once. A read that finds its address returns the stored word in the same cycle, without touching memory. A read that misses fetches the word from memory, hands it to the processor and records it in a slot.

Slots are claimed in arrival order. While a free slot remains, the lowest-numbered free slot is taken. Once every slot is occupied, the slot that was filled longest ago is overwritten. Writes always travel to main memory. They refresh the cached copy when the address is present, and they never claim a slot. Both sides use a plain request/ready exchange. The processor holds its request until the block pulses `cpu_done`. The block holds its memory request until memory answers with `mem_ready`.

Top module: `fa_cache`

## Requirements
- R1: After reset no slot is occupied, `cpu_done` and `mem_req` are low, and the first read of any address misses and goes to memory.
- R2: A read whose address is held in a slot raises `cpu_done` in the cycle it is presented, with the stored word on `cpu_rdata`, and issues no memory read.
- R3: A read miss issues exactly one memory read (`mem_we`=0) of the requested address, returns `mem_rdata` on `cpu_rdata` in the cycle `mem_ready` is high, and installs the pair so that a later read of it hits. No address is ever held in two slots.
- R4: Free slots are used before any occupied slot is overwritten: after 8 distinct read misses from reset, all 8 addresses hit.
- R5: With all slots occupied, a read miss overwrites the pair installed earliest, and every other pair stays resident.
- R6: Hits do not change the replacement order: a pair read many times is still the one overwritten when it is the oldest.
- R7: Every write issues exactly one memory write (`mem_we`=1) with the request address and data, and no memory read. `cpu_done` is raised in the cycle `mem_ready` is high.
- R8: A write to a resident address updates the cached word, so the next read of that address hits and returns the new data.
- R9: A write to an absent address does not claim a slot, so the next read of that address misses.
- R10: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Word address of the request |
| cpu_wdata | input | 16 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid while `cpu_done` is high on a read |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory has completed the request this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |

## Verification
The hardest state to reach from the ports is a full cache whose oldest slot has been hit repeatedly. The bench must then show that a fresh miss still evicts that slot rather than one chosen by recent use. The bench gets there in a directed sequence. It fills all slots with distinct read misses, then rereads the oldest address several times, then issues a new miss, and checks at the memory port that the reread address now misses. A bench-side occupancy model with its own pointer then follows a long pseudo-random mix of reads and writes over an address pool a little larger than the cache. Memory latency varies from zero to three wait cycles, and every access is checked for hit or miss by counting memory reads.

// File: rtl/fa_cache_pkg.sv
// Package: shared types of the fully associative cache.
// Assumes: nothing beyond IEEE 1800-2017.
package fa_cache_pkg;

    // Controller states: idle lookup, fill from memory, store to memory.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_STORE = 2'd2
    } fa_state_e;

endpackage

// File: rtl/fa_entry_store.sv
// Module: fa_entry_store
// Holds ENTRIES slots of {valid, address, data} and compares a lookup
// address against every slot in parallel. One write port either installs
// a full pair (alloc) or refreshes only the data word of a slot.
// Assumes: the controller never installs an address that is already held,
// so at most one hit bit is set.
module fa_entry_store #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [DATA_W-1:0]  hit_data,
    output logic [ENTRIES-1:0] valid_vec,
    input  logic               wr_en,
    input  logic               wr_alloc,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data
);

    logic [ADDR_W-1:0] slot_addr [ENTRIES];
    logic [DATA_W-1:0] slot_data [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Slot storage: reset clears the pair, alloc installs, update refreshes data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                slot_addr[g] <= '0;
                slot_data[g] <= '0;
            end else if (sel) begin
                slot_data[g] <= wr_data;
                if (wr_alloc) begin
                    valid_vec[g] <= 1'b1;
                    slot_addr[g] <= wr_addr;
                end
            end
        end

        // Per-slot comparator.
        assign hit_vec[g] = valid_vec[g] && (slot_addr[g] == lookup_addr);
    end

    // Encode the hit slot and merge its data word.
    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx  = IDX_W'(i);
                hit_data = hit_data | slot_data[i];
            end
        end
    end

endmodule

// File: rtl/fa_victim_sel.sv
// Module: fa_victim_sel
// Chooses the slot for the next install: the lowest free slot if any,
// otherwise the slot under the first-in first-out pointer. The pointer
// moves to the slot after the one just installed, and only on install.
// Assumes: slots are never freed except by reset.
module fa_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim_idx,
    output logic [IDX_W-1:0]   fifo_ptr
);

    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic [IDX_W-1:0] next_ptr;

    // Priority search for the lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Victim choice and the pointer value that follows it.
    always_comb begin
        victim_idx = any_free ? free_idx : fifo_ptr;
        next_ptr   = (victim_idx == IDX_W'(ENTRIES - 1)) ? '0 : victim_idx + 1'b1;
    end

    // Replacement pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)     fifo_ptr <= '0;
        else if (alloc) fifo_ptr <= next_ptr;
    end

endmodule

// File: rtl/fa_ctrl.sv
// Module: fa_ctrl
// Request sequencer. In idle it completes read hits at once, and captures
// read misses and all writes. It then holds one memory request until
// memory answers, installing on a read miss and refreshing the slot on a
// write hit.
// Assumes: the processor holds its request until cpu_done.
module fa_ctrl
    import fa_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              lookup_hit,
    input  logic              mem_ready,
    output fa_state_e         state,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              alloc,
    output logic              upd
);

    fa_state_e state_nx;
    logic      capture;

    // Next state and one-cycle strobes.
    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        cpu_done = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        alloc    = 1'b0;
        upd      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        capture  = 1'b1;
                        state_nx = ST_STORE;
                    end else if (lookup_hit) begin
                        cpu_done = 1'b1;
                    end else begin
                        capture  = 1'b1;
                        state_nx = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    alloc    = 1'b1;
                    cpu_done = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    upd      = lookup_hit;
                    cpu_done = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request capture for the memory phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr  <= '0;
            held_wdata <= '0;
        end else if (capture) begin
            held_addr  <= cpu_addr;
            held_wdata <= cpu_wdata;
        end
    end

endmodule

// File: rtl/fa_cache.sv
// Module: fa_cache (top)
// Fully associative write-through cache with first-in first-out
// replacement. Joins the slot store, the victim selector and the sequencer.
// Assumes: one outstanding processor request and one memory transfer at a time.
module fa_cache
    import fa_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    fa_state_e          state;
    logic [ADDR_W-1:0]  held_addr;
    logic [DATA_W-1:0]  held_wdata;
    logic [ADDR_W-1:0]  lookup_addr;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [DATA_W-1:0]  hit_data;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   fifo_ptr;
    logic               alloc;
    logic               upd;

    // Lookup uses the live address in idle, the captured one afterwards.
    assign lookup_addr = (state == ST_IDLE) ? cpu_addr : held_addr;
    assign cpu_rdata   = (state == ST_FILL) ? mem_rdata : hit_data;
    assign mem_addr    = held_addr;
    assign mem_wdata   = held_wdata;

    fa_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .lookup_hit (|hit_vec),
        .mem_ready  (mem_ready),
        .state      (state),
        .held_addr  (held_addr),
        .held_wdata (held_wdata),
        .cpu_done   (cpu_done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .alloc      (alloc),
        .upd        (upd)
    );

    fa_entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lookup_addr (lookup_addr),
        .hit_vec     (hit_vec),
        .hit_idx     (hit_idx),
        .hit_data    (hit_data),
        .valid_vec   (valid_vec),
        .wr_en       (alloc | upd),
        .wr_alloc    (alloc),
        .wr_idx      (alloc ? victim_idx : hit_idx),
        .wr_addr     (held_addr),
        .wr_data     (alloc ? mem_rdata : held_wdata)
    );

    fa_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .alloc      (alloc),
        .victim_idx (victim_idx),
        .fifo_ptr   (fifo_ptr)
    );

endmodule

// File: rtl/fa_cache_chk.sv
// Module: fa_cache_chk
// Property checker for fa_cache, attached through bind below.
// Assumes: synchronous active-low reset.
module fa_cache_chk #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_we,
    input logic               cpu_done,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]   fifo_ptr,
    input logic               alloc
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

    assert_idle_hit_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !mem_req && (|hit_vec)) |-> cpu_done);

    assert_single_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_fill_free_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !(&valid_vec)) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    assert_ptr_on_alloc_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(fifo_ptr));

    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && mem_we) |-> (mem_req && mem_ready));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind fa_cache fa_cache_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_done  (cpu_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .fifo_ptr  (fifo_ptr),
    .alloc     (alloc)
);

// File: tb/tb_fa_cache.sv
module tb_fa_cache;

    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;

    int total = 0, bad = 0;
    int n_rd = 0, n_wr = 0;
    logic [11:0] last_wa;
    logic [15:0] last_wd;
    logic [15:0] mem_store [4096];
    logic [15:0] exp_mem   [4096];
    logic [11:0] ref_addr  [NE];
    logic        ref_val   [NE];
    int          ref_ptr = 0;
    int          last_drd, last_dwr;
    logic [15:0] last_rd;
    logic        last_hit;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    fa_cache dut (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Memory responder: 0..3 wait cycles, checks the held request.
    initial begin
        logic [11:0] pa; logic pend = 0; int waited = 0; int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 1'b0;
            else if (rst_n && mem_req) begin
                if (pend) chk(mem_addr == pa, "R10", mem_addr, pa);
                pend = 1; pa = mem_addr;
                if (waited >= lat) begin
                    mem_ready = 1'b1; pend = 0; waited = 0;
                    if (mem_we) begin
                        mem_store[mem_addr] = mem_wdata; n_wr++;
                        last_wa = mem_addr; last_wd = mem_wdata;
                    end else begin
                        mem_rdata = mem_store[mem_addr]; n_rd++;
                    end
                    lfsr = step(lfsr); lat = int'(lfsr[1:0]);
                end else waited++;
            end
        end
    end

    function automatic int ref_find(input logic [11:0] a);
        for (int i = 0; i < NE; i++) if (ref_val[i] && ref_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic ref_install(input logic [11:0] a);
        int s = -1;
        for (int i = NE - 1; i >= 0; i--) if (!ref_val[i]) s = i;
        if (s < 0) s = ref_ptr;
        ref_val[s] = 1; ref_addr[s] = a; ref_ptr = (s + 1) % NE;
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [15:0] d);
        int r0 = n_rd, w0 = n_wr;
        last_hit = (ref_find(a) >= 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_done) begin @(negedge clk); #1; end
        last_rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 0;
        last_drd = n_rd - r0; last_dwr = n_wr - w0;
        if (!we) begin
            chk(last_drd == (last_hit ? 0 : 1), last_hit ? "R2" : "R3", last_drd, last_hit ? 0 : 1);
            chk(last_rd == exp_mem[a], last_hit ? "R2" : "R3", last_rd, exp_mem[a]);
            if (!last_hit) ref_install(a);
        end else begin
            exp_mem[a] = d;
            chk(last_dwr == 1 && last_drd == 0, "R7", last_dwr, 1);
            chk(last_wa == a && last_wd == d, "R7", last_wa, a);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] a [12];
        for (int i = 0; i < 4096; i++) begin
            mem_store[i] = 16'(i * 29) ^ 16'h5A3C;
            exp_mem[i]   = mem_store[i];
        end
        for (int i = 0; i < NE; i++) ref_val[i] = 0;
        for (int i = 0; i < 12; i++) a[i] = 12'h100 + 12'(i * 165);

        repeat (3) @(posedge clk);
        #1;
        chk(cpu_done == 0 && mem_req == 0, "R1", {cpu_done, mem_req}, 0);
        @(negedge clk); rst_n = 1;

        // R1, R3: first reads miss and install
        for (int i = 0; i < NE; i++) begin
            access(0, a[i], 0);
            if (i == 0) chk(last_drd == 1, "R1", last_drd, 1);
        end
        // R4: all eight resident
        for (int i = 0; i < NE; i++) begin
            access(0, a[i], 0);
            chk(last_drd == 0, "R4", last_drd, 0);
        end
        // R5: new miss displaces a[0] only
        access(0, a[8], 0);
        for (int i = 1; i < NE; i++) begin
            access(0, a[i], 0);
            chk(last_drd == 0, "R5", last_drd, 0);
        end
        access(0, a[0], 0);
        chk(last_drd == 1, "R5", last_drd, 1);
        // R6: a[2] is oldest; hits on it do not save it
        for (int k = 0; k < 3; k++) access(0, a[2], 0);
        access(0, a[9], 0);
        access(0, a[2], 0);
        chk(last_drd == 1, "R6", last_drd, 1);
        // R8: write hit refreshes cached copy
        access(1, a[5], 16'hBEEF);
        access(0, a[5], 0);
        chk(last_drd == 0 && last_rd == 16'hBEEF, "R8", last_rd, 16'hBEEF);
        // R9: write miss claims no slot
        access(1, a[11], 16'h1234);
        access(0, a[11], 0);
        chk(last_drd == 1 && last_rd == 16'h1234, "R9", last_drd, 1);

        // Pseudo-random sweep over 12 addresses against the reference model
        for (int n = 0; n < 600; n++) begin
            lfsr = step(lfsr);
            access(lfsr[3:2] == 2'b00, a[int'(lfsr[15:8]) % 12], lfsr ^ 16'(n));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule